// File: doc/BRIEF.md
# Read-To-Clear Fault Status Register

This block collects one-cycle fault event pulses and turns each into a sticky flag. The pulses come from per-rail undervoltage and overvoltage comparators, general-purpose inputs, watchdog timers and a manual-reset pin. A host reads the flags through a simple request/acknowledge read port, one 8-bit word at a time. Any read hands back the flags as they stood in the request cycle and then wipes the whole flag set, not just the word that was read. The flags are volatile: after reset they are all clear.

Two details shape what the host sees. First, the first read after reset carries no information: it returns zero with the valid marker low, and every later read returns real data with the marker high. Second, a watchdog can be set up to watch one of the general-purpose inputs. When such a watchdog expires, its own flag and the flag of the input it watches are both set. The manual-reset pin is synchronised inside the block. Each new assertion of the pin sets a dedicated flag once.

Top module: `fault_status_regs`

## Requirements
- R1: An undervoltage event on rail i sets bit i of word 0. An overvoltage event on rail i sets bit i of word 1. With the default of 6 rails, bits 7:6 of both words read 0.
- R2: Word 2 holds the input flags in bits 3:0, the watchdog flags in bits 5:4 and the manual-reset flag in bit 6. Bit 7 of word 2 reads 0. A read of address 3 returns 0.
- R3: A flag, once set, stays set through any number of cycles without a read, and further events only add flags.
- R4: A read request (rd_req high with rd_addr) is answered in the next cycle with rd_ack high for one cycle. rd_data then holds the addressed word as it stood in the request cycle.
- R5: A read of any address, address 3 included, clears every flag in all three words.
- R6: The first read after reset returns 0 with rd_valid low. Every later read drives rd_valid high.
- R7: An event that arrives in the same cycle as a read request is absent from that read's data and is still set after the clear.
- R8: When a watchdog is marked as watching a general-purpose input (wd_on_gpi bit high), its expiry sets both its watchdog flag and the input flag picked by its 2-bit field in wd_gpi_sel (watchdog w uses bits 2w+1:2w).
- R9: When a watchdog is not marked as watching an input, its expiry sets only its watchdog flag.
- R10: A falling edge on mr_n sets the manual-reset flag within three clock edges. Holding mr_n low does not set the flag again after a read has cleared it.
- R11: Asserting rst_n clears all flags, rd_ack and rd_data, and restores the invalid first-read behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_evt | input | N_RAIL | Undervoltage event pulses, one per rail |
| ov_evt | input | N_RAIL | Overvoltage event pulses, one per rail |
| gpi_evt | input | N_GPI | General-purpose input fault pulses |
| wd_evt | input | N_WD | Watchdog expiry pulses |
| wd_on_gpi | input | N_WD | Per watchdog: 1 when it watches a general-purpose input |
| wd_gpi_sel | input | N_WD*2 | Per watchdog: index of the watched input |
| mr_n | input | 1 | Manual-reset pin, active low, asynchronous |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | 2 | Word address: 0 undervoltage, 1 overvoltage, 2 misc, 3 none |
| rd_data | output | 8 | Read data, updated with rd_ack |
| rd_valid | output | 1 | Read data is meaningful (low on first read after reset) |
| rd_ack | output | 1 | One-cycle read response |

## Verification
The hardest case to reach from the ports is an event that lands in the very cycle of a read request. The read must leave out that event, and the event must survive the clear. The bench drives the event and rd_req on the same falling edge. It then checks the response word and a following read, which must show the event. A second hard case is the manual-reset flag set against a pin that is still held low. The bench keeps mr_n low across a read and checks that the next read finds the flag clear.

// File: rtl/fault_status_pkg.sv
package fault_status_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    WORD_UNDER = 2'd0,
    WORD_OVER  = 2'd1,
    WORD_MISC  = 2'd2,
    WORD_NONE  = 2'd3
  } fault_word_e;
endpackage

// File: rtl/fault_event_map.sv
module fault_event_map #(
  parameter int N_GPI = 4,
  parameter int N_WD  = 2,
  parameter int SEL_W = 2
) (
  input  logic [N_GPI-1:0]      gpi_evt,
  input  logic [N_WD-1:0]       wd_evt,
  input  logic [N_WD-1:0]       wd_on_gpi,
  input  logic [N_WD*SEL_W-1:0] wd_gpi_sel,
  output logic [N_GPI-1:0]      gpi_set
);
  always_comb begin
    gpi_set = gpi_evt;
    for (int w = 0; w < N_WD; w++) begin
      if (wd_evt[w] && wd_on_gpi[w]) begin
        gpi_set[wd_gpi_sel[w*SEL_W +: SEL_W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_mr_edge.sv
module fault_mr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n,
  output logic mr_set
);
  logic [SYNC_STAGES:0] pipe_q;
  logic [SYNC_STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[SYNC_STAGES-1:0], mr_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  // falling edge of the synchronised pin: older stage high, newer stage low
  assign mr_set = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] set,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] flags_d;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    // a set in the clearing cycle wins over the clear
    always_comb begin
      flags_d[b] = set[b] | (flags_q[b] & ~clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/fault_read_port.sv
module fault_read_port
  import fault_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] word_under,
  input  logic [WORD_W-1:0] word_over,
  input  logic [WORD_W-1:0] word_misc,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_ack,
  output logic              clr_all
);
  logic [WORD_W-1:0] data_q, data_d, sel_word;
  logic              valid_q, valid_d;
  logic              ack_q, ack_d;
  logic              seen_q, seen_d;

  always_comb begin
    unique case (fault_word_e'(rd_addr))
      WORD_UNDER: sel_word = word_under;
      WORD_OVER:  sel_word = word_over;
      WORD_MISC:  sel_word = word_misc;
      default:    sel_word = '0;
    endcase
  end

  always_comb begin
    data_d  = data_q;
    valid_d = valid_q;
    seen_d  = seen_q;
    ack_d   = 1'b0;
    if (rd_req) begin
      ack_d   = 1'b1;
      valid_d = seen_q;
      seen_d  = 1'b1;
      data_d  = seen_q ? sel_word : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ack_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      ack_q   <= ack_d;
      seen_q  <= seen_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
  assign rd_ack   = ack_q;
  assign clr_all  = rd_req;
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
  import fault_status_pkg::*;
#(
  parameter int N_RAIL = 6,
  parameter int N_GPI  = 4,
  parameter int N_WD   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_RAIL-1:0]   uv_evt,
  input  logic [N_RAIL-1:0]   ov_evt,
  input  logic [N_GPI-1:0]    gpi_evt,
  input  logic [N_WD-1:0]     wd_evt,
  input  logic [N_WD-1:0]     wd_on_gpi,
  input  logic [N_WD*2-1:0]   wd_gpi_sel,
  input  logic                mr_n,
  input  logic                rd_req,
  input  logic [1:0]          rd_addr,
  output logic [7:0]          rd_data,
  output logic                rd_valid,
  output logic                rd_ack
);
  localparam int OV_OFF  = N_RAIL;
  localparam int GPI_OFF = 2 * N_RAIL;
  localparam int WD_OFF  = GPI_OFF + N_GPI;
  localparam int MR_OFF  = WD_OFF + N_WD;
  localparam int FLAG_W  = MR_OFF + 1;

  logic [N_GPI-1:0]  gpi_set;
  logic              mr_set;
  logic              clr_all;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] flags_q;
  logic [WORD_W-1:0] word_under, word_over, word_misc;

  fault_event_map #(.N_GPI(N_GPI), .N_WD(N_WD), .SEL_W(SEL_W)) i_map (
    .gpi_evt   (gpi_evt),
    .wd_evt    (wd_evt),
    .wd_on_gpi (wd_on_gpi),
    .wd_gpi_sel(wd_gpi_sel),
    .gpi_set   (gpi_set)
  );

  fault_mr_edge #(.SYNC_STAGES(2)) i_mr (
    .clk   (clk),
    .rst_n (rst_n),
    .mr_n  (mr_n),
    .mr_set(mr_set)
  );

  assign set_vec = {mr_set, wd_evt, gpi_set, ov_evt, uv_evt};

  fault_flag_bank #(.WIDTH(FLAG_W)) i_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr_all),
    .set  (set_vec),
    .flags(flags_q)
  );

  assign word_under = WORD_W'(flags_q[OV_OFF-1:0]);
  assign word_over  = WORD_W'(flags_q[GPI_OFF-1:OV_OFF]);
  assign word_misc  = WORD_W'(flags_q[FLAG_W-1:GPI_OFF]);

  fault_read_port i_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .word_under(word_under),
    .word_over (word_over),
    .word_misc (word_misc),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ack    (rd_ack),
    .clr_all   (clr_all)
  );
endmodule

// File: rtl/fault_status_chk.sv
module fault_status_chk #(
  parameter int N_RAIL = 6,
  parameter int N_GPI  = 4,
  parameter int N_WD   = 2,
  parameter int FLAG_W = 2 * N_RAIL + N_GPI + N_WD + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_ack,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] set_vec,
  input logic [N_WD-1:0]   wd_evt,
  input logic [N_WD-1:0]   wd_on_gpi,
  input logic [N_WD*2-1:0] wd_gpi_sel
);
  localparam int GPI_OFF = 2 * N_RAIL;
  localparam int WD_OFF  = GPI_OFF + N_GPI;

  // R4
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);

  // R4
  ack_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_ack);

  // R3
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> ((flags & $past(flags)) == $past(flags)));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && set_vec == '0) |=> (flags == '0));

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R6
  first_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !rd_valid) |-> (rd_data == 8'h00));

  // R6
  valid_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_valid);

  for (genvar w = 0; w < N_WD; w++) begin : g_wd
    // R8
    wd_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_evt[w] && wd_on_gpi[w]) |=>
        (flags[WD_OFF + w] && flags[GPI_OFF + int'($past(wd_gpi_sel[w*2 +: 2]))]));
  end
endmodule

bind fault_status_regs fault_status_chk #(
  .N_RAIL(N_RAIL), .N_GPI(N_GPI), .N_WD(N_WD)
) i_fault_status_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_req    (rd_req),
  .rd_ack    (rd_ack),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .flags     (flags_q),
  .set_vec   (set_vec),
  .wd_evt    (wd_evt),
  .wd_on_gpi (wd_on_gpi),
  .wd_gpi_sel(wd_gpi_sel)
);

// File: tb/test_fault_status_regs.sv
module test_fault_status_regs;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] uv_evt, ov_evt;
  logic [3:0] gpi_evt;
  logic [1:0] wd_evt, wd_on_gpi;
  logic [3:0] wd_gpi_sel;
  logic       mr_n, rd_req;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       rd_valid, rd_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_status_regs i_fault_status_regs (
    .clk(clk), .rst_n(rst_n), .uv_evt(uv_evt), .ov_evt(ov_evt),
    .gpi_evt(gpi_evt), .wd_evt(wd_evt), .wd_on_gpi(wd_on_gpi),
    .wd_gpi_sel(wd_gpi_sel), .mr_n(mr_n), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ack(rd_ack)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic idle_inputs();
    uv_evt = '0; ov_evt = '0; gpi_evt = '0; wd_evt = '0;
    rd_req = 1'b0; rd_addr = '0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // issue a read at a falling edge, sample the response one edge later
  task automatic do_read(input logic [1:0] addr, output logic [7:0] data,
                         output logic valid, output logic ack);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_req = 1'b0;
    data = rd_data; valid = rd_valid; ack = rd_ack;
  endtask

  task automatic pulse(input logic [5:0] uv, input logic [5:0] ov,
                       input logic [3:0] gp, input logic [1:0] wd);
    @(negedge clk);
    uv_evt = uv; ov_evt = ov; gpi_evt = gp; wd_evt = wd;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset_and_first_read();
    logic [7:0] d; logic v, a;
    apply_reset();
    check("R11 ack low after reset", int'(rd_ack), 0);
    check("R11 data zero after reset", int'(rd_data), 0);
    pulse(6'h01, '0, '0, '0);
    do_read(2'd0, d, v, a);
    check("R6 first read data", int'(d), 0);
    check("R6 first read valid", int'(v), 0);
    check("R4 ack on first read", int'(a), 1);
    do_read(2'd0, d, v, a);
    check("R5 first read cleared flag", int'(d), 0);
    check("R6 later read valid", int'(v), 1);
  endtask

  task automatic t_rail_words();
    logic [7:0] d; logic v, a;
    pulse(6'h21, '0, '0, '0);
    do_read(2'd0, d, v, a);
    check("R1 undervoltage word", int'(d), 'h21);
    pulse('0, 6'h12, '0, '0);
    do_read(2'd1, d, v, a);
    check("R1 overvoltage word", int'(d), 'h12);
    check("R4 ack on read", int'(a), 1);
  endtask

  task automatic t_clear_all();
    logic [7:0] d; logic v, a;
    pulse(6'h3f, 6'h3f, 4'hf, '0);
    do_read(2'd1, d, v, a);
    check("R1 all overvoltage bits", int'(d), 'h3f);
    do_read(2'd0, d, v, a);
    check("R5 undervoltage cleared by word1 read", int'(d), 0);
    do_read(2'd2, d, v, a);
    check("R5 misc cleared by word1 read", int'(d), 0);
    pulse(6'h04, '0, '0, '0);
    do_read(2'd3, d, v, a);
    check("R2 address 3 reads zero", int'(d), 0);
    do_read(2'd0, d, v, a);
    check("R5 address 3 read cleared flags", int'(d), 0);
  endtask

  task automatic t_sticky();
    logic [7:0] d; logic v, a;
    pulse('0, '0, 4'b0010, '0);
    repeat (10) @(negedge clk);
    pulse('0, '0, 4'b1000, '0);
    repeat (5) @(negedge clk);
    do_read(2'd2, d, v, a);
    check("R3 sticky input flags", int'(d), 'h0a);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 2'd0; uv_evt = 6'h04;
    @(negedge clk);
    idle_inputs();
    d = rd_data;
    check("R7 event absent from same-cycle read", int'(d), 0);
    begin
      logic v, a;
      do_read(2'd0, d, v, a);
      check("R7 event survives clear", int'(d), 'h04);
    end
  endtask

  task automatic t_watchdog();
    logic [7:0] d; logic v, a;
    wd_on_gpi = 2'b01; wd_gpi_sel = 4'b00_10;
    pulse('0, '0, '0, 2'b01);
    do_read(2'd2, d, v, a);
    check("R8 watchdog on input sets both bits", int'(d), 'h14);
    pulse('0, '0, '0, 2'b10);
    do_read(2'd2, d, v, a);
    check("R9 standalone watchdog bit only", int'(d), 'h20);
    wd_on_gpi = 2'b00;
  endtask

  task automatic t_manual_reset();
    logic [7:0] d; logic v, a;
    @(negedge clk);
    mr_n = 1'b0;
    repeat (4) @(negedge clk);
    do_read(2'd2, d, v, a);
    check("R10 manual-reset flag", int'(d), 'h40);
    repeat (4) @(negedge clk);
    do_read(2'd2, d, v, a);
    check("R10 held pin does not re-set", int'(d), 0);
    mr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_midrun();
    logic [7:0] d; logic v, a;
    pulse(6'h3f, 6'h3f, 4'hf, 2'b11);
    apply_reset();
    do_read(2'd0, d, v, a);
    check("R11 reset restores invalid first read", int'(v), 0);
    do_read(2'd1, d, v, a);
    check("R11 reset cleared flags", int'(d), 0);
  endtask

  initial begin
    rst_n = 1'b0; mr_n = 1'b1; wd_on_gpi = '0; wd_gpi_sel = '0;
    idle_inputs();
    t_reset_and_first_read();
    t_rail_words();
    t_clear_all();
    t_sticky();
    t_same_cycle();
    t_watchdog();
    t_manual_reset();
    t_reset_midrun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule